// File: doc/BRIEF.md
# Accumulator Multicycle Core

A small processor core built around one accumulator. Every instruction is stepped through a fixed set of phases, one register transfer per clock. The phases are instruction fetch, decode, operand address formation, an optional pointer read, operand read, execute and operand write. Each instruction class takes only the phases it needs. The holding registers are a program counter, a memory address register, a memory buffer register, an opcode register and the accumulator. Two flags, negative and zero, sit beside the accumulator.

The core drives a simple synchronous word memory. It presents an address, write data and separate read and write strobes. Read data is taken one cycle after the read strobe. The instruction word holds a 4-bit opcode in its top bits, then an indirect-mode bit, then a direct address field. The program counter is advanced in the same cycle as the instruction read, so no extra cycle is spent on the increment.

Top module: `acc_core`

## Requirements
- R1: A synchronous reset clears PC, AC and both flags and puts the core in the first fetch phase. In the first cycle after reset release neither strobe is active. In the second cycle a read strobe is issued at address 0.
- R2: A fetch puts PC in the address register, then strobes a read while PC advances by one. Instructions that do not branch are therefore fetched from consecutive addresses.
- R3: Instruction format: bits [15:12] are the opcode and bit [11] is the indirect-mode bit. Bits [10:0] are the direct address, zero-extended to the 12-bit address bus.
- R4: LOAD (opcode 0001) sets AC to the word at the effective address.
- R5: ADD (opcode 1001) sets AC to AC plus the word at the effective address, modulo 2^16. For a direct ADD or LOAD, the operand read strobe comes 4 cycles after the instruction read strobe. The next instruction read comes 8 cycles after it.
- R6: STORE (opcode 0010) writes AC to the effective address with one write strobe. It performs no operand read.
- R7: SHL (opcode 0101) shifts AC left one place, with a zero entering bit 0. It makes no memory access other than its own fetch.
- R8: BRA (opcode 0011) loads PC with the effective address. BN (opcode 0100) does the same only when the N flag is set; otherwise execution continues at the next address.
- R9: When the indirect-mode bit is 1, the word at the direct address is read first. Its low 12 bits then become the effective address. This applies to LOAD, ADD, STORE, BRA and BN.
- R10: Whenever AC is written, N takes bit 15 of the new value and Z is set exactly when the new value is zero.
- R11: Opcodes not listed above act as no-ops. They change neither memory nor AC and return to fetch.
- R12: The read and write strobes are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 12 | Word address for memory reads and writes |
| mem_rd | output | 1 | Read strobe; data is expected on mem_rdata the next cycle |
| mem_wr | output | 1 | Write strobe; mem_wdata is written to mem_addr at the clock edge |
| mem_wdata | output | 16 | Data to be written |
| mem_rdata | input | 16 | Data returned by memory one cycle after a read strobe |

## Verification
The bench builds the core with its default 16-bit word, which gives a 12-bit address and an 11-bit direct field. A single program, placed in a bench memory model, exercises the following behaviour:
- direct and indirect LOAD, ADD and STORE;
- an add that wraps to zero;
- a shift that drops a set top bit;
- a branch on N, both not taken and taken;
- an undefined opcode;
- an indirect unconditional branch into a self-loop.

Decoys are placed where a wrong branch would land, and beyond a skipped store, so that any misroute shows up as an unexpected memory write or fetch. Cycle offsets between instruction and operand read strobes are measured against the phase counts.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OPC_LOAD  = 4'b0001;
  localparam logic [OP_W-1:0] OPC_STORE = 4'b0010;
  localparam logic [OP_W-1:0] OPC_BRA   = 4'b0011;
  localparam logic [OP_W-1:0] OPC_BN    = 4'b0100;
  localparam logic [OP_W-1:0] OPC_SHL   = 4'b0101;
  localparam logic [OP_W-1:0] OPC_ADD   = 4'b1001;

  typedef enum logic [3:0] {
    ST_FA,   // address register <- PC
    ST_FR,   // instruction read strobe, PC advance
    ST_FW,   // buffer <- read data
    ST_DEC,  // opcode register <- opcode field
    ST_OAC,  // address register <- direct field
    ST_IR,   // pointer read strobe
    ST_IW,   // buffer <- pointer
    ST_IM,   // address register <- pointer
    ST_OFR,  // operand read strobe
    ST_OFW,  // buffer <- operand
    ST_EX,   // execute
    ST_OSL,  // buffer <- AC
    ST_OSW   // write strobe
  } state_e;

  typedef enum logic [1:0] {AOP_NONE, AOP_LOAD, AOP_ADD, AOP_SHL} aop_e;
  typedef enum logic [1:0] {MAR_HOLD, MAR_PC, MAR_FIELD, MAR_PTR} marsel_e;
  typedef enum logic [1:0] {MBR_HOLD, MBR_MEM, MBR_ACC} mbrsel_e;

  typedef struct packed {
    marsel_e mar_sel;
    mbrsel_e mbr_sel;
    logic    ir_load;
    logic    pc_inc;
    logic    pc_load;
    aop_e    aop;
    logic    rd;
    logic    wr;
  } ctl_t;

  typedef struct packed {
    logic ld;
    logic st;
    logic add;
    logic shl;
    logic bra;
    logic bn;
    logic known;
  } cls_t;
endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_pkg::*;
(
  input  logic [OP_W-1:0] opc,
  output cls_t            cls
);
  always_comb begin
    cls       = '0;
    cls.ld    = (opc == OPC_LOAD);
    cls.st    = (opc == OPC_STORE);
    cls.add   = (opc == OPC_ADD);
    cls.shl   = (opc == OPC_SHL);
    cls.bra   = (opc == OPC_BRA);
    cls.bn    = (opc == OPC_BN);
    cls.known = cls.ld | cls.st | cls.add | cls.shl | cls.bra | cls.bn;
  end
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  cls_t   cls,
  input  logic   ind_bit,
  input  logic   flag_n,
  output state_e state,
  output ctl_t   ctl
);
  state_e nxt;

  // after the address is known, pick the phase this class needs next
  function automatic state_e route(input cls_t c);
    if (c.ld || c.add)      return ST_OFR;
    else if (c.st)          return ST_OSL;
    else                    return ST_EX;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FA;
    else     state <= nxt;
  end

  always_comb begin
    nxt = state;
    unique case (state)
      ST_FA:  nxt = ST_FR;
      ST_FR:  nxt = ST_FW;
      ST_FW:  nxt = ST_DEC;
      ST_DEC: begin
        if (!cls.known)   nxt = ST_FA;
        else if (cls.shl) nxt = ST_EX;
        else              nxt = ST_OAC;
      end
      ST_OAC: nxt = ind_bit ? ST_IR : route(cls);
      ST_IR:  nxt = ST_IW;
      ST_IW:  nxt = ST_IM;
      ST_IM:  nxt = route(cls);
      ST_OFR: nxt = ST_OFW;
      ST_OFW: nxt = ST_EX;
      ST_EX:  nxt = ST_FA;
      ST_OSL: nxt = ST_OSW;
      ST_OSW: nxt = ST_FA;
      default: nxt = ST_FA;
    endcase
  end

  always_comb begin
    ctl         = '0;
    ctl.mar_sel = MAR_HOLD;
    ctl.mbr_sel = MBR_HOLD;
    ctl.aop     = AOP_NONE;
    unique case (state)
      ST_FA:  ctl.mar_sel = MAR_PC;
      ST_FR:  begin ctl.rd = 1'b1; ctl.pc_inc = 1'b1; end
      ST_FW:  ctl.mbr_sel = MBR_MEM;
      ST_DEC: ctl.ir_load = 1'b1;
      ST_OAC: ctl.mar_sel = MAR_FIELD;
      ST_IR:  ctl.rd = 1'b1;
      ST_IW:  ctl.mbr_sel = MBR_MEM;
      ST_IM:  ctl.mar_sel = MAR_PTR;
      ST_OFR: ctl.rd = 1'b1;
      ST_OFW: ctl.mbr_sel = MBR_MEM;
      ST_EX: begin
        if (cls.ld)       ctl.aop = AOP_LOAD;
        else if (cls.add) ctl.aop = AOP_ADD;
        else if (cls.shl) ctl.aop = AOP_SHL;
        ctl.pc_load = cls.bra | (cls.bn & flag_n);
      end
      ST_OSL: ctl.mbr_sel = MBR_ACC;
      ST_OSW: ctl.wr = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = DATA_W - OP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  ctl_t              ctl,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mbr,
  output logic [OP_W-1:0]   ir,
  output logic [DATA_W-1:0] acc,
  output logic              flag_n,
  output logic              flag_z
);
  localparam int FIELD_W = ADDR_W - 1;
  localparam logic [ADDR_W-1:0] PC_STEP = 1;

  function automatic logic [DATA_W-1:0] f_add(input logic [DATA_W-1:0] a,
                                              input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic [DATA_W-1:0] f_shl(input logic [DATA_W-1:0] a);
    return {a[DATA_W-2:0], 1'b0};
  endfunction

  function automatic logic [DATA_W-1:0] f_alu(input aop_e op,
                                              input logic [DATA_W-1:0] a,
                                              input logic [DATA_W-1:0] b);
    unique case (op)
      AOP_LOAD: return b;
      AOP_ADD:  return f_add(a, b);
      AOP_SHL:  return f_shl(a);
      default:  return a;
    endcase
  endfunction

  logic [DATA_W-1:0] acc_next;
  logic [ADDR_W-1:0] mar_field;
  logic [ADDR_W-1:0] mar_ptr;

  assign acc_next  = f_alu(ctl.aop, acc, mbr);
  assign mar_field = {1'b0, mbr[FIELD_W-1:0]};
  assign mar_ptr   = mbr[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= '0;
      mar    <= '0;
      mbr    <= '0;
      ir     <= '0;
      acc    <= '0;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
    end else begin
      unique case (ctl.mar_sel)
        MAR_PC:    mar <= pc;
        MAR_FIELD: mar <= mar_field;
        MAR_PTR:   mar <= mar_ptr;
        default:   ;
      endcase
      unique case (ctl.mbr_sel)
        MBR_MEM: mbr <= rdata;
        MBR_ACC: mbr <= acc;
        default: ;
      endcase
      if (ctl.ir_load) ir <= mbr[DATA_W-1 -: OP_W];
      if (ctl.pc_load)     pc <= mar;
      else if (ctl.pc_inc) pc <= pc + PC_STEP;
      if (ctl.aop != AOP_NONE) begin
        acc    <= acc_next;
        flag_n <= acc_next[DATA_W-1];
        flag_z <= (acc_next == '0);
      end
    end
  end
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = DATA_W - OP_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  state_e            state;
  ctl_t              ctl;
  cls_t              cls;
  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] mar;
  logic [DATA_W-1:0] mbr;
  logic [OP_W-1:0]   ir;
  logic [DATA_W-1:0] acc;
  logic              flag_n;
  logic              flag_z;
  logic [OP_W-1:0]   opc_sel;

  // named events for the checker
  logic acc_wr;
  logic fetch_rd;
  logic fetch_idle;
  logic undef_dec;

  // in decode the opcode is still only in the buffer; later phases use IR
  assign opc_sel = (state == ST_DEC) ? mbr[DATA_W-1 -: OP_W] : ir;

  acc_decode u_dec (
    .opc (opc_sel),
    .cls (cls)
  );

  acc_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .cls     (cls),
    .ind_bit (mbr[ADDR_W-1]),
    .flag_n  (flag_n),
    .state   (state),
    .ctl     (ctl)
  );

  acc_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl),
    .rdata  (mem_rdata),
    .pc     (pc),
    .mar    (mar),
    .mbr    (mbr),
    .ir     (ir),
    .acc    (acc),
    .flag_n (flag_n),
    .flag_z (flag_z)
  );

  assign mem_addr   = mar;
  assign mem_wdata  = mbr;
  assign mem_rd     = ctl.rd;
  assign mem_wr     = ctl.wr;

  assign acc_wr     = (ctl.aop != AOP_NONE);
  assign fetch_rd   = (state == ST_FR);
  assign fetch_idle = (state == ST_FA);
  assign undef_dec  = (state == ST_DEC) && !cls.known;
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [ADDR_W-1:0] pc,
  input logic [DATA_W-1:0] acc,
  input logic              flag_n,
  input logic              flag_z,
  input logic              acc_wr,
  input logic              fetch_rd,
  input logic              fetch_idle,
  input logic              undef_dec
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!mem_rd && !mem_wr));

  a_r2_fetch_from_pc: assert property (@(posedge clk) disable iff (rst)
    fetch_rd |-> (mem_rd && mem_addr == pc));

  a_r2_pc_advances: assert property (@(posedge clk) disable iff (rst)
    fetch_rd |=> (pc == $past(pc) + 1'b1));

  a_r12_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  a_r6_store_data_is_acc: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (mem_wdata == acc));

  a_r10_flags_follow_acc: assert property (@(posedge clk) disable iff (rst)
    acc_wr |=> (flag_n == acc[DATA_W-1] && flag_z == (acc == '0)));

  a_r11_undefined_returns: assert property (@(posedge clk) disable iff (rst)
    undef_dec |=> (fetch_idle && !mem_wr));
endmodule

bind acc_core acc_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/acc_core_bench.sv
module acc_core_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mem_addr;
  logic        mem_rd;
  logic        mem_wr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 8 ns period

  acc_core u_acc_core (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  // synchronous memory model, data one cycle after the read strobe
  logic [15:0] mem [0:1023];
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
    if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;
  end

  typedef struct {
    logic [11:0] a;
    logic [15:0] d;
    string       tag;
  } wr_item_t;
  wr_item_t exp_q[$];

  task automatic push_exp(input logic [11:0] a, input logic [15:0] d, input string tag);
    wr_item_t it;
    it.a = a; it.d = d; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  // R3 format: opcode [15:12], indirect [11], direct [10:0]
  function automatic logic [15:0] ins(input logic [3:0] op, input logic ind,
                                      input logic [10:0] a);
    return {op, ind, a};
  endfunction

  // monitor: pops expected writes and records read strobe timing
  int cyc = 0;
  int t_fetch0 = -1;
  int t_op0 = -1;
  int t_fetch1 = -1;
  int loop_cnt = 0;
  int trap_cnt = 0;
  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (mem_rd) begin
        if (mem_addr == 12'h000 && t_fetch0 < 0) t_fetch0 = cyc;
        if (mem_addr == 12'h100 && t_op0 < 0)    t_op0 = cyc;
        if (mem_addr == 12'h001 && t_fetch1 < 0) t_fetch1 = cyc;
        if (mem_addr == 12'h022) loop_cnt++;
        if (mem_addr == 12'h00F) trap_cnt++;
      end
      if (mem_wr) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected write", int'(mem_addr), 0);
        end else begin
          wr_item_t it;
          it = exp_q.pop_front();
          check(mem_addr == it.a, {it.tag, " address"}, int'(mem_addr), int'(it.a));
          check(mem_wdata == it.d, {it.tag, " data"}, int'(mem_wdata), int'(it.d));
        end
      end
    end
  end

  initial begin
    bit done;
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
    // data
    mem[12'h100] = 16'h0005;
    mem[12'h101] = 16'h0003;
    mem[12'h102] = 16'h0103;
    mem[12'h103] = 16'h8001;
    mem[12'h104] = 16'h0202;
    mem[12'h105] = 16'hFFFF;
    mem[12'h106] = 16'h0001;
    mem[12'h107] = 16'h0020;
    mem[12'h108] = 16'h7FFF;
    // program
    mem[12'h000] = ins(4'b0001, 1'b0, 11'h100);  // LOAD
    mem[12'h001] = ins(4'b1001, 1'b0, 11'h101);  // ADD
    mem[12'h002] = ins(4'b0010, 1'b0, 11'h200);  // STORE
    mem[12'h003] = ins(4'b0101, 1'b0, 11'h000);  // SHL
    mem[12'h004] = ins(4'b0010, 1'b0, 11'h201);  // STORE
    mem[12'h005] = ins(4'b0001, 1'b1, 11'h102);  // LOAD indirect
    mem[12'h006] = ins(4'b0010, 1'b1, 11'h104);  // STORE indirect
    mem[12'h007] = ins(4'b0101, 1'b0, 11'h000);  // SHL, top bit lost
    mem[12'h008] = ins(4'b0010, 1'b0, 11'h203);  // STORE
    mem[12'h009] = ins(4'b0100, 1'b0, 11'h00F);  // BN not taken
    mem[12'h00A] = ins(4'b0001, 1'b0, 11'h105);  // LOAD negative
    mem[12'h00B] = ins(4'b0100, 1'b0, 11'h010);  // BN taken
    mem[12'h00C] = ins(4'b0010, 1'b0, 11'h2FF);  // decoy
    mem[12'h00F] = ins(4'b0010, 1'b0, 11'h2FD);  // decoy
    mem[12'h010] = 16'hF000;                     // undefined opcode
    mem[12'h011] = ins(4'b1001, 1'b0, 11'h106);  // ADD wraps to zero
    mem[12'h012] = ins(4'b0010, 1'b0, 11'h204);  // STORE
    mem[12'h013] = ins(4'b0011, 1'b1, 11'h107);  // BRA indirect
    mem[12'h014] = ins(4'b0010, 1'b0, 11'h2FE);  // decoy
    mem[12'h020] = ins(4'b1001, 1'b0, 11'h108);  // ADD
    mem[12'h021] = ins(4'b0010, 1'b0, 11'h205);  // STORE
    mem[12'h022] = ins(4'b0011, 1'b0, 11'h022);  // BRA self

    // expected writes, worked out from the requirements
    push_exp(12'h200, 16'(16'h0005 + 16'h0003), "R4 R5 load add store");
    push_exp(12'h201, 16'(16'h0008 << 1), "R7 shift store");
    push_exp(12'h202, 16'h8001, "R9 indirect load and store");
    push_exp(12'h203, 16'(16'h8001 << 1), "R7 shift drops top bit");
    push_exp(12'h204, 16'(16'hFFFF + 16'h0001), "R5 R11 wrap after no-op");
    push_exp(12'h205, 16'h7FFF, "R8 R9 indirect branch target");

    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(!mem_rd && !mem_wr, "R1 quiet first cycle", {mem_rd, mem_wr}, 0);
    @(negedge clk);
    check(mem_rd && mem_addr == 12'h000, "R1 first fetch at 0", int'(mem_addr), 0);

    done = 1'b0;
    for (int i = 0; i < 20000 && !done; i++) begin
      @(negedge clk);
      if (loop_cnt >= 2) done = 1'b1;
    end
    check(done, "R8 watchdog self-loop reached", loop_cnt, 2);
    repeat (20) @(negedge clk);

    check(t_op0 - t_fetch0 == 4, "R5 operand read offset", t_op0 - t_fetch0, 4);
    check(t_fetch1 - t_fetch0 == 8, "R2 next fetch offset", t_fetch1 - t_fetch0, 8);
    check(trap_cnt == 0, "R8 BN not taken when N clear", trap_cnt, 0);
    check(exp_q.size() == 0, "R6 all stores seen", exp_q.size(), 0);
    check(mem[12'h2FF] == 16'h0 && mem[12'h2FE] == 16'h0, "R8 skipped decoys untouched",
          int'(mem[12'h2FF] | mem[12'h2FE]), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule